// File: doc/BRIEF.md
# Two-Die Byte SRAM Controller

This block lets a synchronous host read and write single bytes in a 1 MiB space. The space is built from two asynchronous static RAM dies of 512K x 8 each. Both dies share one address bus, one byte-wide data path and one active-low output enable. Each die has its own active-low chip enable and its own active-low write enable.

The host raises a request with a 20-bit byte address, a write flag and write data. It holds the request until it sees a one-cycle acknowledge. For reads, the byte arrives on the same cycle as that acknowledge. Address bit 19 chooses the die and bits 18:0 go to the shared address bus.

The controller holds every strobe low for a fixed number of clock cycles. That number is the access time divided by the clock period, rounded up. After a write it keeps the address and data one extra cycle. It never selects both dies at once, and it never drives the data path while output enable is low. The data path is split into an output byte, an output enable for the driver and an input byte, so that the pad tristate can sit at the chip edge.

Top module: `dual_die_sram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, both chip enables, both write enables and the output enable are high, the data driver enable is low and acknowledge is low.
- R2: Host address bit 19 selects the die: 0 pulls only chip enable bit 0 low and 1 pulls only chip enable bit 1 low. Host address bits 18:0 appear unchanged on the die address bus throughout the access.
- R3: The two chip enables are never low in the same cycle.
- R4: A write holds the selected die's chip enable and write enable low for WAIT_CYC cycles. During that time output enable stays high, the driver is enabled and the accepted byte is on the output data.
- R5: In the cycle after the write enable returns high, both chip enables are high while the address, the output byte and the driver enable stay unchanged.
- R6: A read holds the selected die's chip enable and the output enable low for WAIT_CYC cycles, with both write enables high. The input byte is captured at the end of the last of those cycles, never earlier than ACCESS_NS after the strobes settled.
- R7: Acknowledge is high for exactly one cycle per access, with all strobes high. On a read, the read data output holds the byte last written to that address during that cycle.
- R8: The driver enable is high only while output enable is high. It is low in the acknowledge cycle of a write, so at least one undriven cycle separates a write from a following read.
- R9: A request is taken only when the controller is idle. Changes to the request address, write flag or write data during an access have no effect on that access.
- R10: WAIT_CYC equals ACCESS_NS divided by CLK_PERIOD_NS rounded up: 4 cycles for 25 ns at an 8 ns clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address; bit 19 picks the die |
| req_wdata | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with acknowledge |
| mem_addr | output | 19 | Shared die address |
| mem_ce_n | output | 2 | Per-die chip enable, active low |
| mem_we_n | output | 2 | Per-die write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 8 | Byte driven toward the dies |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_i | input | 8 | Byte returned from the dies |

## Verification
The bench models the dies with a timestamp on the last strobe or address change. A die returns a junk byte until 25 ns have passed since that change, so a controller that samples one cycle early reads junk instead of the stored byte. The two dies are written at the same low address with different bytes and then read back in turn. A decode that ignores bit 19, or that enables both dies, returns the wrong byte or breaks the one-die rule.

A write followed at once by a read checks that the driver is off in the acknowledge cycle; a design that drops that gap would collide with the die's output. The request inputs change in the middle of an access, so a controller that keeps re-sampling them puts the new address or data on the bus. A reset during a read checks that every strobe returns high at once.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_HOLD,
    ST_DONE
  } dds_state_e;

  // rounded-up integer division, used for cycle counts from nanoseconds
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/dds_bank_decode.sv
module dds_bank_decode #(
  parameter int ADDR_W = 20,
  parameter int BANKS  = 2
) (
  input  logic [ADDR_W-1:0]                  host_addr,
  output logic [ADDR_W-$clog2(BANKS)-1:0]    die_addr,
  output logic [BANKS-1:0]                   die_sel
);
  localparam int BANK_BITS = $clog2(BANKS);
  localparam int DIE_AW    = ADDR_W - BANK_BITS;

  assign die_addr = host_addr[DIE_AW-1:0];

  for (genvar g = 0; g < BANKS; g++) begin : g_sel
    assign die_sel[g] = (host_addr[ADDR_W-1 -: BANK_BITS] == BANK_BITS'(g));
  end
endmodule

// File: rtl/dds_wait_timer.sv
module dds_wait_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(CYCLES - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dual_die_sram_ctrl.sv
module dual_die_sram_ctrl #(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int ACCESS_NS     = 25
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                ack,
  output logic [DATA_W-1:0]   rdata,
  output logic [ADDR_W-2:0]   mem_addr,
  output logic [1:0]          mem_ce_n,
  output logic [1:0]          mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W-1:0]   mem_dq_o,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_i
);
  import dds_pkg::*;

  localparam int BANKS    = 2;
  localparam int DIE_AW   = ADDR_W - 1;
  localparam int RAW_WAIT = ceil_div(ACCESS_NS, CLK_PERIOD_NS);
  localparam int WAIT_CYC = (RAW_WAIT < 1) ? 1 : RAW_WAIT;

  dds_state_e          state;
  logic [DIE_AW-1:0]   die_addr;
  logic [BANKS-1:0]    die_sel;
  logic                start;
  logic                expired;

  assign start = (state == ST_IDLE) && req_valid;

  dds_bank_decode #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_decode (
    .host_addr (req_addr),
    .die_addr  (die_addr),
    .die_sel   (die_sel)
  );

  dds_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (start),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ack       <= 1'b0;
      rdata     <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= '1;
      mem_we_n  <= '1;
      mem_oe_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mem_addr <= die_addr;
            mem_ce_n <= ~die_sel;
            if (req_write) begin
              mem_we_n  <= ~die_sel;
              mem_dq_o  <= req_wdata;
              mem_dq_oe <= 1'b1;
              state     <= ST_WRITE;
            end else begin
              mem_oe_n <= 1'b0;
              state    <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (expired) begin
            rdata    <= mem_dq_i;
            mem_ce_n <= '1;
            mem_oe_n <= 1'b1;
            ack      <= 1'b1;
            state    <= ST_DONE;
          end
        end
        ST_WRITE: begin
          if (expired) begin
            mem_we_n <= '1;
            mem_ce_n <= '1;
            state    <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          mem_dq_oe <= 1'b0;
          ack       <= 1'b1;
          state     <= ST_DONE;
        end
        ST_DONE: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dds_ctrl_checker.sv
module dds_ctrl_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic [ADDR_W-2:0] mem_addr,
  input logic [1:0]        mem_ce_n,
  input logic [1:0]        mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_ce_n == 2'b11 && mem_we_n == 2'b11 && mem_oe_n && !mem_dq_oe && !ack));

  a_r3_one_die: assert property (@(posedge clk) disable iff (rst)
    $countones(~mem_ce_n) <= 1);

  a_r4_we_with_ce: assert property (@(posedge clk) disable iff (rst)
    ((~mem_we_n & mem_ce_n) == 2'b00) && ((mem_we_n != 2'b11) -> mem_dq_oe));

  a_r5_write_hold: assert property (@(posedge clk) disable iff (rst)
    ((&mem_we_n) && !$past(&mem_we_n)) |->
      (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o) && mem_ce_n == 2'b11));

  a_r6_read_we_high: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n == 2'b11));

  a_r7_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  a_r8_turnaround: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
endmodule

bind dual_die_sram_ctrl dds_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack       (ack),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/dual_die_sram_ctrl_bench.sv
`timescale 1ns/100ps
module dual_die_sram_ctrl_bench;
  localparam int    PERIOD   = 8;
  localparam int    ACC_NS   = 25;
  localparam int    EXP_WAIT = (ACC_NS + PERIOD - 1) / PERIOD;   // R10
  localparam logic [7:0] JUNK = 8'hEE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr  = '0;
  logic [7:0]  req_wdata = '0;
  logic        ack;
  logic [7:0]  rdata;
  logic [18:0] mem_addr;
  logic [1:0]  mem_ce_n;
  logic [1:0]  mem_we_n;
  logic        mem_oe_n;
  logic [7:0]  mem_dq_o;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_i = JUNK;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] sram   [int];
  logic [7:0] shadow [int];
  realtime    t_chg = 0.0;

  always #(PERIOD/2) clk = ~clk;

  dual_die_sram_ctrl #(.CLK_PERIOD_NS(PERIOD), .ACCESS_NS(ACC_NS)) u_dual_die_sram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // die model: timestamp of the last strobe/address change gates read data
  always @(mem_ce_n or mem_oe_n or mem_we_n or mem_addr) t_chg = $realtime;

  initial begin
    #0.5;
    forever begin
      if (mem_ce_n == 2'b10 || mem_ce_n == 2'b01) begin
        automatic int die = (mem_ce_n == 2'b10) ? 0 : 1;
        automatic int idx = die * (1 << 19) + int'(mem_addr);
        if (!mem_we_n[die] && mem_dq_oe) sram[idx] = mem_dq_o;
        if (!mem_oe_n && mem_we_n[die] && ($realtime - t_chg) >= ACC_NS)
          mem_dq_i = sram.exists(idx) ? sram[idx] : 8'h00;
        else
          mem_dq_i = JUNK;
      end else begin
        mem_dq_i = JUNK;
      end
      #1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp(input logic [1:0] ce, input logic [1:0] we, input logic oe,
                     input logic dqoe, input logic ak, input bit chk_a,
                     input logic [18:0] a, input bit chk_d, input logic [7:0] d,
                     input string req);
    chk(mem_ce_n === ce, req, "chip enables", 32'(mem_ce_n), 32'(ce));
    chk(mem_we_n === we, req, "write enables", 32'(mem_we_n), 32'(we));
    chk(mem_oe_n === oe, req, "output enable", 32'(mem_oe_n), 32'(oe));
    chk(mem_dq_oe === dqoe, req, "driver enable", 32'(mem_dq_oe), 32'(dqoe));
    chk(ack === ak, req, "ack", 32'(ack), 32'(ak));
    if (chk_a) chk(mem_addr === a, req, "die address", 32'(mem_addr), 32'(a));
    if (chk_d) chk(mem_dq_o === d, req, "output byte", 32'(mem_dq_o), 32'(d));
  endtask

  task automatic access(input bit wr, input logic [19:0] a, input logic [7:0] d,
                        input bit perturb);
    logic [1:0] sel_n;
    sel_n = a[19] ? 2'b01 : 2'b10;   // R2
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    for (int k = 0; k < EXP_WAIT; k++) begin
      @(negedge clk);
      if (wr) cmp(sel_n, sel_n, 1'b1, 1'b1, 1'b0, 1'b1, a[18:0], 1'b1, d, "R4");
      else    cmp(sel_n, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, a[18:0], 1'b0, 8'h00, "R6");
      if (perturb && k == 0) begin   // R9: mid-access input changes
        req_addr = a ^ 20'h80001; req_wdata = ~d; req_write = ~wr;
      end
    end
    if (wr) begin
      @(negedge clk);
      cmp(2'b11, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, a[18:0], 1'b1, d, "R5");
    end
    @(negedge clk);
    cmp(2'b11, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, 8'h00, wr ? "R8" : "R7");
    if (!wr) begin
      automatic logic [7:0] e = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      chk(rdata === e, "R7", "read data", 32'(rdata), 32'(e));
    end else begin
      shadow[int'(a)] = d;
    end
    req_valid = 1'b0;
    @(negedge clk);
    cmp(2'b11, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 8'h00, "R7");
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL R7 watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp(2'b11, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 8'h00, "R1");
    rst = 1'b0;
    @(negedge clk);
    cmp(2'b11, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 8'h00, "R1");

    // write then immediate read: turnaround (R8) and timing (R6, R10)
    access(1'b1, 20'h00010, 8'h5A, 1'b0);
    access(1'b0, 20'h00010, 8'h00, 1'b0);
    // same low address on the other die (R2, R3)
    access(1'b1, 20'h80010, 8'hC3, 1'b0);
    access(1'b0, 20'h00010, 8'h00, 1'b0);
    access(1'b0, 20'h80010, 8'h00, 1'b0);
    // address extremes
    access(1'b1, 20'h7FFFF, 8'h81, 1'b0);
    access(1'b1, 20'hFFFFF, 8'h18, 1'b0);
    access(1'b1, 20'h00000, 8'hFF, 1'b0);
    access(1'b1, 20'h80000, 8'h01, 1'b0);
    access(1'b0, 20'h7FFFF, 8'h00, 1'b0);
    access(1'b0, 20'hFFFFF, 8'h00, 1'b0);
    access(1'b0, 20'h00000, 8'h00, 1'b0);
    access(1'b0, 20'h80000, 8'h00, 1'b0);
    // R9: inputs change during an access
    access(1'b1, 20'h92344, 8'h77, 1'b0);
    access(1'b1, 20'h12345, 8'h11, 1'b1);
    access(1'b0, 20'h12345, 8'h00, 1'b1);
    access(1'b0, 20'h92344, 8'h00, 1'b0);
    // mixed pattern
    for (int i = 0; i < 12; i++)
      access(1'b1, 20'((i * 20'h1A2B7) ^ (i[0] ? 20'h80000 : 20'h0)), 8'(i * 37 + 5), 1'b0);
    for (int i = 11; i >= 0; i--)
      access(1'b0, 20'((i * 20'h1A2B7) ^ (i[0] ? 20'h80000 : 20'h0)), 8'h00, 1'b0);

    // reset in the middle of a read (R1)
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h80010;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    cmp(2'b11, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 8'h00, "R1");
    rst = 1'b0;
    @(negedge clk);
    cmp(2'b11, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 8'h00, "R1");
    access(1'b0, 20'h80010, 8'h00, 1'b0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule